// File: doc/BRIEF.md
# Unpacked Floating-Point Adder

This block adds or subtracts two floating-point operands that an earlier stage has already unpacked. Each operand arrives as a class code, a sign, a signed unbiased exponent and a fixed-point mantissa with an explicit integer bit. The block resolves special operands in a fixed priority order and aligns the exponents, keeping a sticky bit for the bits shifted out. It then adds or subtracts the mantissas and normalises the result. It also raises two invalid-operation flags. The result leaves unpacked, with its own sticky bit, for a separate rounding and packing stage.

A request is one cycle long. `start` captures the operands, `sub` and the two-bit rounding mode, and the registered result appears together with a one-cycle `done` pulse on the next cycle. The rounding mode only decides the sign of exact-zero results. No rounding is done here.

On opposite signs the block always forms x minus y without comparing magnitudes first. Here x is the operand with the larger exponent, or the first operand when the exponents are equal. A borrow out of that subtraction is repaired by a two's-complement negate.

Top module: `fp_unpacked_adder`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `start` high, and the result and flag outputs change only in that cycle. After reset all outputs are zero.
- R2: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. The mantissa is MANT_W bits, bit MANT_W-1 weighs 2.0 and bit MANT_W-2 weighs 1.0, and a normal number has the 1.0 bit set. With `sub` high the second operand's sign is inverted before any other step.
- R3: If either operand is a NaN, the result is the first operand when it is a NaN and otherwise the second operand, passed through unchanged. `flag_snan` is set when either operand is a signalling NaN.
- R4: Two infinities of opposite effective sign give `flag_inf_sub` and the default NaN: class 3, sign 0, exponent 0, mantissa with only bits MANT_W-2 and MANT_W-3 set. Any other case with an infinity returns that infinity, and the second operand wins when both are infinities.
- R5: Two zero operands give a zero whose sign is the OR of the signs when `rmode` is 2'b11 (toward minus infinity), and the AND of the signs for every other mode.
- R6: When exactly one operand is zero, the result is the other operand unchanged, with sticky 0.
- R7: For two numbers the operand with the larger exponent becomes x, and the result exponent starts from x's exponent. The other mantissa is shifted right by the exponent difference, and any nonzero bit shifted out, including a full shift-out, sets the sticky bit.
- R8: With like signs the aligned mantissas are summed. A sum of 2.0 or more is shifted right one place, its lost bit is ORed into sticky, and the exponent is increased by one.
- R9: With unlike signs the result is x minus aligned y minus sticky, with x's sign. A difference below 1.0 is shifted left until bit MANT_W-2 is set, and the exponent is lowered by the shift count, while sticky is kept.
- R10: When that subtraction borrows out, the difference is negated in two's complement and the result takes the effective sign of y.
- R11: An exact-zero difference gives a zero with exponent 0 and mantissa 0, negative only when `rmode` is 2'b11. Every zero result has exponent 0 and mantissa 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture operands and compute |
| sub | input | 1 | Subtract: invert second operand's sign |
| rmode | input | 2 | Rounding mode, 2'b11 is toward minus infinity |
| a_cls | input | 3 | First operand class |
| a_sign | input | 1 | First operand sign |
| a_exp | input | EXP_W | First operand exponent, signed |
| a_mant | input | MANT_W | First operand mantissa |
| b_cls | input | 3 | Second operand class |
| b_sign | input | 1 | Second operand sign |
| b_exp | input | EXP_W | Second operand exponent, signed |
| b_mant | input | MANT_W | Second operand mantissa |
| done | output | 1 | Result valid pulse |
| r_cls | output | 3 | Result class |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent, signed |
| r_mant | output | MANT_W | Result mantissa |
| r_sticky | output | 1 | Bits lost below the mantissa |
| flag_snan | output | 1 | Invalid: signalling NaN operand |
| flag_inf_sub | output | 1 | Invalid: infinity minus infinity |

## Verification
The number path is driven with equal exponents and like signs, with and without a carry past 2.0. The same path is driven with a carry that drops a one bit, so that the shift is distinguished from the sticky fold. Exponent gaps of one, two and far beyond the mantissa width show whether alignment picks the right operand, and whether the sticky bit comes from partial or total shift-out. Unlike-sign cases cover a positive difference, a borrow case with equal exponents, exact cancellation under two rounding modes, and a difference where sticky acts as the borrow-in. That last case separates a correct borrow-in from a plain truncated subtract. Special-operand cases show the priority order by pairing NaNs with numbers and infinities, infinities with each other, and zeros with both signs.

// File: rtl/fp_unpacked_adder.sv
module fp_unpacked_adder #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub,
  input  logic [1:0]        rmode,
  input  logic [2:0]        a_cls,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [2:0]        b_cls,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              done,
  output logic [2:0]        r_cls,
  output logic              r_sign,
  output logic [EXP_W-1:0]  r_exp,
  output logic [MANT_W-1:0] r_mant,
  output logic              r_sticky,
  output logic              flag_snan,
  output logic              flag_inf_sub
);
  localparam logic [2:0] C_ZERO = 3'd0, C_NUM = 3'd1, C_INF = 3'd2,
                         C_QNAN = 3'd3, C_SNAN = 3'd4;
  localparam logic [1:0] RM_DOWN = 2'b11;
  localparam int SH_W = $clog2(MANT_W) + 1;
  localparam logic [MANT_W-1:0] QNAN_M = {3'b011, {(MANT_W-3){1'b0}}};

  logic b_sgn;
  assign b_sgn = b_sign ^ sub;

  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
  assign a_nan  = (a_cls == C_QNAN) || (a_cls == C_SNAN);
  assign b_nan  = (b_cls == C_QNAN) || (b_cls == C_SNAN);
  assign a_inf  = a_cls == C_INF;
  assign b_inf  = b_cls == C_INF;
  assign a_zero = a_cls == C_ZERO;
  assign b_zero = b_cls == C_ZERO;

  logic swap;
  assign swap = $signed(b_exp) > $signed(a_exp);

  logic              xs, ys;
  logic [EXP_W-1:0]  xe, ye;
  logic [MANT_W-1:0] xm, ym;
  assign xs = swap ? b_sgn  : a_sign;
  assign ys = swap ? a_sign : b_sgn;
  assign xe = swap ? b_exp  : a_exp;
  assign ye = swap ? a_exp  : b_exp;
  assign xm = swap ? b_mant : a_mant;
  assign ym = swap ? a_mant : b_mant;

  logic [EXP_W:0]    diff;
  logic              far;
  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] ya;
  logic              lost;
  assign diff = {xe[EXP_W-1], xe} - {ye[EXP_W-1], ye};
  assign far  = diff >= (EXP_W+1)'(MANT_W);
  assign sh   = diff[SH_W-1:0];
  assign ya   = far ? '0 : (ym >> sh);
  assign lost = far ? (|ym) : ((sh == '0) ? 1'b0 : (|(ym << (SH_W'(MANT_W) - sh))));

  logic [MANT_W-1:0] sum;
  logic [MANT_W:0]   dif;
  logic              borrow;
  logic [MANT_W-1:0] mag;
  assign sum    = xm + ya;
  assign dif    = {1'b0, xm} - {1'b0, ya} - (MANT_W+1)'(lost);
  assign borrow = dif[MANT_W];
  assign mag    = borrow ? (~dif[MANT_W-1:0] + 1'b1) : dif[MANT_W-1:0];

  logic [SH_W-1:0] lz;
  logic            found;
  always_comb begin
    lz = '0;
    found = 1'b0;
    for (int i = MANT_W-2; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz = SH_W'(MANT_W-2-i);
        found = 1'b1;
      end
    end
  end

  logic              n_sign, n_stk, n_fsn, n_fii;
  logic [2:0]        n_cls;
  logic [EXP_W-1:0]  n_exp;
  logic [MANT_W-1:0] n_mant;

  always_comb begin
    n_cls = C_ZERO; n_sign = 1'b0; n_exp = '0; n_mant = '0;
    n_stk = 1'b0; n_fsn = 1'b0; n_fii = 1'b0;
    if (a_nan || b_nan) begin
      n_fsn = (a_cls == C_SNAN) || (b_cls == C_SNAN);
      if (a_nan) {n_cls, n_sign, n_exp, n_mant} = {a_cls, a_sign, a_exp, a_mant};
      else       {n_cls, n_sign, n_exp, n_mant} = {b_cls, b_sgn, b_exp, b_mant};
    end else if (a_inf || b_inf) begin
      if (a_inf && b_inf && (a_sign != b_sgn)) begin
        n_fii = 1'b1; n_cls = C_QNAN; n_mant = QNAN_M;
      end else if (b_inf) {n_cls, n_sign, n_exp, n_mant} = {b_cls, b_sgn, b_exp, b_mant};
      else                {n_cls, n_sign, n_exp, n_mant} = {a_cls, a_sign, a_exp, a_mant};
    end else if (a_zero && b_zero) begin
      n_sign = (rmode == RM_DOWN) ? (a_sign | b_sgn) : (a_sign & b_sgn);
    end else if (a_zero) begin
      {n_cls, n_sign, n_exp, n_mant} = {b_cls, b_sgn, b_exp, b_mant};
    end else if (b_zero) begin
      {n_cls, n_sign, n_exp, n_mant} = {a_cls, a_sign, a_exp, a_mant};
    end else begin
      n_cls = C_NUM; n_exp = xe; n_stk = lost;
      if (xs == ys) begin
        n_sign = xs;
        if (sum[MANT_W-1]) begin
          n_mant = sum >> 1;
          n_stk  = lost | sum[0];
          n_exp  = xe + 1'b1;
        end else begin
          n_mant = sum;
        end
      end else if (mag == '0) begin
        n_cls = C_ZERO; n_sign = (rmode == RM_DOWN); n_exp = '0; n_stk = 1'b0;
      end else begin
        n_sign = borrow ? ys : xs;
        n_mant = mag << lz;
        n_exp  = xe - EXP_W'(lz);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; r_cls <= C_ZERO; r_sign <= 1'b0; r_exp <= '0; r_mant <= '0;
      r_sticky <= 1'b0; flag_snan <= 1'b0; flag_inf_sub <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        r_cls <= n_cls; r_sign <= n_sign; r_exp <= n_exp; r_mant <= n_mant;
        r_sticky <= n_stk; flag_snan <= n_fsn; flag_inf_sub <= n_fii;
      end
    end
  end
endmodule

// File: rtl/fp_unpacked_adder_chk.sv
module fp_unpacked_adder_chk #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [2:0]        r_cls,
  input logic              r_sign,
  input logic [EXP_W-1:0]  r_exp,
  input logic [MANT_W-1:0] r_mant,
  input logic              flag_snan,
  input logic              flag_inf_sub
);
  // R1
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(r_mant) && $stable(r_exp) && $stable(r_cls) && $stable(r_sign)
                && $stable(flag_snan) && $stable(flag_inf_sub)));

  // R3
  snan_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_snan) |-> (r_cls == 3'd3 || r_cls == 3'd4));

  // R4
  inf_sub_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_inf_sub) |-> (r_cls == 3'd3 && !flag_snan && !r_sign));

  // R11
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && r_cls == 3'd0) |-> (r_mant == '0 && r_exp == '0));
endmodule

bind fp_unpacked_adder fp_unpacked_adder_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/tb_fp_unpacked_adder.sv
`timescale 1ns/1ps
module tb_fp_unpacked_adder;
  localparam int MW = 64;
  localparam int EW = 16;
  localparam logic [MW-1:0] ONE  = 64'h4000_0000_0000_0000;
  localparam logic [MW-1:0] ONEH = 64'h6000_0000_0000_0000;
  localparam logic [2:0] Z = 3'd0, N = 3'd1, I = 3'd2, Q = 3'd3, S = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sub = 1'b0;
  logic [1:0] rmode = 2'b00;
  logic [2:0] a_cls = '0, b_cls = '0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic done, r_sign, r_sticky, flag_snan, flag_inf_sub;
  logic [2:0] r_cls;
  logic [EW-1:0] r_exp;
  logic [MW-1:0] r_mant;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  fp_unpacked_adder #(.MANT_W(MW), .EXP_W(EW)) dut (.*);

  task automatic chk(input string req, input logic [2:0] ec, input logic es,
                     input logic [EW-1:0] ee, input logic [MW-1:0] em, input logic est,
                     input logic efs, input logic efi);
    checks++;
    if ({done, r_cls, r_sign, r_exp, r_mant, r_sticky, flag_snan, flag_inf_sub} !==
        {1'b1, ec, es, ee, em, est, efs, efi}) begin
      fails++;
      $display("FAIL %s: got done=%b cls=%0d s=%b e=%h m=%h st=%b fs=%b fi=%b exp cls=%0d s=%b e=%h m=%h st=%b fs=%b fi=%b",
               req, done, r_cls, r_sign, r_exp, r_mant, r_sticky, flag_snan, flag_inf_sub,
               ec, es, ee, em, est, efs, efi);
    end
  endtask

  task automatic apply(input logic sb, input logic [1:0] rm,
                       input logic [2:0] ac, input logic as, input logic [EW-1:0] ae, input logic [MW-1:0] am,
                       input logic [2:0] bc, input logic bs, input logic [EW-1:0] be, input logic [MW-1:0] bm);
    @(negedge clk);
    sub = sb; rmode = rm;
    a_cls = ac; a_sign = as; a_exp = ae; a_mant = am;
    b_cls = bc; b_sign = bs; b_exp = be; b_mant = bm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    checks++;
    if ({done, r_cls, r_sign, r_exp, r_mant, r_sticky, flag_snan, flag_inf_sub} !== '0) begin
      fails++;
      $display("FAIL R1: reset outputs not zero, done=%b m=%h exp all zero", done, r_mant);
    end
  endtask

  task automatic t_hold;
    apply(0, 0, N, 0, 16'd3, ONE, N, 0, 16'd3, ONE);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || r_mant !== ONE || r_exp !== 16'd4) begin
      fails++;
      $display("FAIL R1: hold got done=%b m=%h e=%h exp done=0 m=%h e=0004", done, r_mant, r_exp, ONE);
    end
  endtask

  task automatic t_nan;
    apply(0, 0, S, 1, 16'd7, 64'h5000_0000_0000_0000, N, 0, 16'd0, ONE);
    chk("R3 snan a", S, 1, 16'd7, 64'h5000_0000_0000_0000, 0, 1, 0);
    apply(1, 0, N, 0, 16'd0, ONE, Q, 0, 16'd2, ONEH);
    chk("R3 qnan b sub", Q, 1, 16'd2, ONEH, 0, 0, 0);
    apply(0, 0, Q, 0, 16'd1, ONEH, S, 1, 16'd0, ONE);
    chk("R3 qnan a snan b", Q, 0, 16'd1, ONEH, 0, 1, 0);
    apply(0, 0, I, 0, 16'd0, '0, Q, 0, 16'd0, ONEH);
    chk("R3 nan beats inf", Q, 0, 16'd0, ONEH, 0, 0, 0);
  endtask

  task automatic t_inf;
    apply(1, 0, I, 0, 16'd0, '0, I, 0, 16'd0, '0);
    chk("R4 inf-inf", Q, 0, 16'd0, 64'h6000_0000_0000_0000, 0, 0, 1);
    apply(0, 0, I, 1, 16'd0, '0, N, 0, 16'd5, ONE);
    chk("R4 inf+num", I, 1, 16'd0, '0, 0, 0, 0);
    apply(0, 0, I, 1, 16'd0, '0, I, 1, 16'd0, '0);
    chk("R4 like infs", I, 1, 16'd0, '0, 0, 0, 0);
  endtask

  task automatic t_zero;
    apply(0, 2'b00, Z, 0, 16'd0, '0, Z, 1, 16'd0, '0);
    chk("R5 +0+-0 near", Z, 0, 16'd0, '0, 0, 0, 0);
    apply(0, 2'b11, Z, 0, 16'd0, '0, Z, 1, 16'd0, '0);
    chk("R5 +0+-0 down", Z, 1, 16'd0, '0, 0, 0, 0);
    apply(0, 2'b01, Z, 1, 16'd0, '0, Z, 1, 16'd0, '0);
    chk("R5 -0+-0", Z, 1, 16'd0, '0, 0, 0, 0);
    apply(1, 2'b00, Z, 0, 16'd0, '0, Z, 0, 16'd0, '0);
    chk("R5 R2 +0-+0", Z, 0, 16'd0, '0, 0, 0, 0);
  endtask

  task automatic t_onezero;
    apply(0, 0, Z, 0, 16'd0, '0, N, 1, 16'd5, ONEH);
    chk("R6 zero a", N, 1, 16'd5, ONEH, 0, 0, 0);
    apply(1, 0, N, 0, 16'hFFF0, ONE, Z, 0, 16'd0, '0);
    chk("R6 zero b", N, 0, 16'hFFF0, ONE, 0, 0, 0);
    apply(1, 0, Z, 0, 16'd0, '0, N, 0, 16'd2, ONE);
    chk("R6 R2 0-num", N, 1, 16'd2, ONE, 0, 0, 0);
  endtask

  task automatic t_like;
    apply(0, 0, N, 0, 16'd0, ONE, N, 0, 16'd0, ONE);
    chk("R8 1+1", N, 0, 16'd1, ONE, 0, 0, 0);
    apply(0, 0, N, 1, 16'd0, ONEH, N, 1, 16'd0, ONEH);
    chk("R8 -1.5-1.5", N, 1, 16'd1, ONEH, 0, 0, 0);
    apply(0, 0, N, 0, 16'd0, ONE | 64'd1, N, 0, 16'd0, ONE);
    chk("R8 carry lost bit", N, 0, 16'd1, ONE, 1, 0, 0);
  endtask

  task automatic t_align;
    apply(0, 0, N, 0, 16'd0, ONE, N, 0, 16'd2, ONE);
    chk("R7 gap 2 swap", N, 0, 16'd2, 64'h5000_0000_0000_0000, 0, 0, 0);
    apply(0, 0, N, 0, 16'd1, ONE, N, 0, 16'd0, ONE | 64'd1);
    chk("R7 gap 1 sticky", N, 0, 16'd1, ONEH, 1, 0, 0);
    apply(0, 0, N, 0, 16'd100, ONE, N, 0, 16'd0, ONE);
    chk("R7 full shift-out", N, 0, 16'd100, ONE, 1, 0, 0);
  endtask

  task automatic t_unlike;
    apply(1, 0, N, 0, 16'd0, ONEH, N, 0, 16'd0, ONE);
    chk("R9 1.5-1", N, 0, 16'hFFFF, ONE, 0, 0, 0);
    apply(1, 0, N, 0, 16'd0, ONE, N, 0, 16'd0, ONEH);
    chk("R10 1-1.5 borrow", N, 1, 16'hFFFF, ONE, 0, 0, 0);
    apply(0, 0, N, 0, 16'd0, ONE, N, 1, 16'd1, ONE);
    chk("R9 1+-2", N, 1, 16'd0, ONE, 0, 0, 0);
    apply(1, 0, N, 0, 16'd1, ONE, N, 0, 16'd0, ONE | 64'd1);
    chk("R9 sticky borrow-in", N, 0, 16'hFFFF, 64'h7FFF_FFFF_FFFF_FFFC, 1, 0, 0);
  endtask

  task automatic t_cancel;
    apply(1, 2'b00, N, 0, 16'd3, ONEH, N, 0, 16'd3, ONEH);
    chk("R11 cancel near", Z, 0, 16'd0, '0, 0, 0, 0);
    apply(1, 2'b11, N, 1, 16'd3, ONEH, N, 1, 16'd3, ONEH);
    chk("R11 cancel down", Z, 1, 16'd0, '0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hold();
    t_nan();
    t_inf();
    t_zero();
    t_onezero();
    t_like();
    t_align();
    t_unlike();
    t_cancel();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule